// File: doc/BRIEF.md
# Configurable Registered Address Buffer

This block sits on the command and address path of a memory module. It captures an input word on the rising clock edge and drives registered outputs that match the inputs bit for bit. Two strap inputs fix the configuration. In the wide configuration, 25 input lanes pass straight to 25 outputs. In the fan-out configuration, 14 input lanes are captured and each captured bit drives two output positions. A second strap chooses which 14 input lanes feed the fan-out, so that two copies of the block can split one 28-lane bus between them.

A pair of chip-select inputs sets a low-power hold. When both are high at a clock edge, that edge captures nothing, and every registered output, the registered copy of the first chip select included, keeps its value. If the second chip select is tied low, the first one is only an ordinary registered bit. An active-low reset acts without waiting for a clock. It clears all state and wins over the hold.

Top module: `rb_addr_buffer`

## Requirements
- R1: With `fanout_mode` low, `dout[24:0]` equals `din[24:0]` as sampled at the most recent capturing rising edge, so there is one edge of latency.
- R2: With `fanout_mode` high, both `dout[13:0]` and `dout[27:14]` equal the 14 selected input lanes as sampled at the most recent capturing edge. Output bit k and output bit k+14 carry selected lane k.
- R3: With `fanout_mode` low, the three spare outputs `dout[27:25]` are always 0.
- R4: With `fanout_mode` high, `half_sel` low selects input lanes `din[13:0]` and `half_sel` high selects input lanes `din[24:11]`. Selected lane k is `din[k]` or `din[k+11]` respectively.
- R5: At a rising edge where `cs_a` and `cs_b` are both 1, neither `dout` nor `cs_a_q` changes. If either one is 0, the edge captures normally.
- R6: While `rst_n` is 0, `dout` and `cs_a_q` are 0. This takes effect at once, without a clock edge, and holds even when both chip selects are 1.
- R7: At every capturing edge, `cs_a_q` takes the value of `cs_a`, not inverted. With `cs_b` held at 0 this happens at every edge, whatever `cs_a` is.
- R8: With `fanout_mode` high, input lanes outside the selected 14 have no effect on `dout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fanout_mode | input | 1 | Strap: 0 = 25-lane straight mode, 1 = 14-lane dual-copy mode |
| half_sel | input | 1 | Strap: in dual-copy mode, 0 = low lanes, 1 = high lanes |
| cs_a | input | 1 | First chip select, also captured to `cs_a_q` |
| cs_b | input | 1 | Second chip select, only gates the hold |
| din | input | 25 | Input lanes |
| dout | output | 28 | Registered output positions |
| cs_a_q | output | 1 | Registered copy of `cs_a` |

## Verification
The hardest case to reach is a reset pulse that falls between two clock edges while the hold is active. The outputs must drop to zero with no edge, and then stay at zero through an edge at which both chip selects are high. The bench asserts reset 1 ns after an edge, checks the outputs before the next edge, and keeps the hold active across that edge. A second hard case is showing that unselected lanes are ignored. For this, the bench toggles only the lanes outside the chosen 14 and compares the output against the previous capture.

// File: rtl/rb_pkg.sv
// Shared sizing for the registered address buffer.
// Assumes WIDE_W >= NARROW_W and 2*NARROW_W >= WIDE_W.
package rb_pkg;
    localparam int unsigned WIDE_W   = 25;           // lanes in straight mode
    localparam int unsigned NARROW_W = 14;           // lanes in dual-copy mode
    localparam int unsigned OUT_W    = 2 * NARROW_W; // output positions
    localparam int unsigned HI_BASE  = WIDE_W - NARROW_W; // first high-half lane
endpackage

// File: rtl/rb_lane_select.sv
// Lane selector: in straight mode it passes all input lanes. In dual-copy
// mode it packs the chosen NARROW_W lanes into the low bits and zeroes the rest.
// Assumes the straps are static while out of reset.
module rb_lane_select #(
    parameter int unsigned WIDE_W   = rb_pkg::WIDE_W,
    parameter int unsigned NARROW_W = rb_pkg::NARROW_W
) (
    input  logic              fanout_mode,
    input  logic              half_sel,
    input  logic [WIDE_W-1:0] din,
    output logic [WIDE_W-1:0] word
);
    localparam int unsigned HI_BASE = WIDE_W - NARROW_W;

    // One mux per lane, resolved at elaboration by lane position.
    for (genvar i = 0; i < WIDE_W; i++) begin : g_lane
        if (i < NARROW_W) begin : g_used
            assign word[i] = fanout_mode ? (half_sel ? din[i + HI_BASE] : din[i]) : din[i];
        end else begin : g_wide_only
            assign word[i] = fanout_mode ? 1'b0 : din[i];
        end
    end
endmodule

// File: rtl/rb_capture_reg.sv
// Capture register: loads the selected word and the first chip select on
// each rising edge unless the hold is active. Asynchronous active-low clear.
// Assumes hold is already the AND of both chip selects.
module rb_capture_reg #(
    parameter int unsigned WIDE_W = rb_pkg::WIDE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [WIDE_W-1:0] d,
    input  logic              cs_in,
    output logic [WIDE_W-1:0] q,
    output logic              cs_q
);
    // Capture or hold the data word and the chip-select copy.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            cs_q <= 1'b0;
        end else if (!hold) begin
            q    <= d;
            cs_q <= cs_in;
        end
    end

    // R5: a held edge leaves the stored state untouched
    assert_hold_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(q) && $stable(cs_q)));

    // R7: a capturing edge copies the chip select without inversion
    assert_cs_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> (cs_q == $past(cs_in)));
endmodule

// File: rtl/rb_fanout.sv
// Output fan-out: in straight mode it drives the stored word and zeroes the
// spare positions. In dual-copy mode it drives the low NARROW_W stored bits twice.
// Assumes the straps are static while out of reset.
module rb_fanout #(
    parameter int unsigned WIDE_W   = rb_pkg::WIDE_W,
    parameter int unsigned NARROW_W = rb_pkg::NARROW_W
) (
    input  logic                  fanout_mode,
    input  logic [WIDE_W-1:0]     q,
    output logic [2*NARROW_W-1:0] dout
);
    localparam int unsigned OUT_W = 2 * NARROW_W;

    // One driver per output position, chosen by where it falls.
    for (genvar j = 0; j < OUT_W; j++) begin : g_pos
        if (j < NARROW_W) begin : g_first_copy
            assign dout[j] = q[j];
        end else if (j < WIDE_W) begin : g_shared
            assign dout[j] = fanout_mode ? q[j - NARROW_W] : q[j];
        end else begin : g_spare
            assign dout[j] = fanout_mode ? q[j - NARROW_W] : 1'b0;
        end
    end
endmodule

// File: rtl/rb_addr_buffer.sv
// Top of the configurable registered address buffer: lane select, capture
// register with chip-select hold, and output fan-out.
// Assumes a single clock and static straps, changed only under reset.
module rb_addr_buffer #(
    parameter int unsigned WIDE_W   = rb_pkg::WIDE_W,
    parameter int unsigned NARROW_W = rb_pkg::NARROW_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fanout_mode,
    input  logic                  half_sel,
    input  logic                  cs_a,
    input  logic                  cs_b,
    input  logic [WIDE_W-1:0]     din,
    output logic [2*NARROW_W-1:0] dout,
    output logic                  cs_a_q
);
    localparam int unsigned OUT_W   = 2 * NARROW_W;
    localparam int unsigned HI_BASE = WIDE_W - NARROW_W;

    logic [WIDE_W-1:0] sel_word;
    logic [WIDE_W-1:0] stored;
    logic              hold;

    // Low-power hold needs both chip selects high.
    always_comb hold = cs_a & cs_b;

    rb_lane_select #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_sel (
        .fanout_mode (fanout_mode),
        .half_sel    (half_sel),
        .din         (din),
        .word        (sel_word)
    );

    rb_capture_reg #(.WIDE_W(WIDE_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .d     (sel_word),
        .cs_in (cs_a),
        .q     (stored),
        .cs_q  (cs_a_q)
    );

    rb_fanout #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_out (
        .fanout_mode (fanout_mode),
        .q           (stored),
        .dout        (dout)
    );

    // R1: straight mode passes the sampled lanes after one edge
    assert_straight_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fanout_mode && !hold) |=> (dout[WIDE_W-1:0] == $past(din)));

    // R2: dual-copy mode drives identical halves
    assert_twin_halves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fanout_mode |-> (dout[NARROW_W-1:0] == dout[OUT_W-1:NARROW_W]));

    // R3: spare positions stay low in straight mode
    assert_spare_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fanout_mode |-> (dout[OUT_W-1:WIDE_W] == '0));

    // R4: low-half selection
    assert_low_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fanout_mode && !half_sel && !hold) |=> (dout[NARROW_W-1:0] == $past(din[NARROW_W-1:0])));

    // R4: high-half selection
    assert_high_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fanout_mode && half_sel && !hold) |=> (dout[NARROW_W-1:0] == $past(din[WIDE_W-1:HI_BASE])));

    // R5: the outputs freeze across a held edge
    assert_out_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(dout));
endmodule

// File: tb/rb_addr_buffer_test.sv
`timescale 1ns/1ps
module rb_addr_buffer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fanout_mode = 1'b0;
    logic        half_sel = 1'b0;
    logic        cs_a = 1'b0;
    logic        cs_b = 1'b0;
    logic [24:0] din = '0;
    logic [27:0] dout;
    logic        cs_a_q;

    int vectors = 0;
    int fails = 0;
    logic [27:0] exp_dout = '0;
    logic        exp_cs = 1'b0;
    logic [31:0] seed = 32'h1234_5678;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    rb_addr_buffer uut (
        .clk(clk), .rst_n(rst_n), .fanout_mode(fanout_mode), .half_sel(half_sel),
        .cs_a(cs_a), .cs_b(cs_b), .din(din), .dout(dout), .cs_a_q(cs_a_q)
    );

    // Expected output word from the lane rules of R1..R4.
    function automatic logic [27:0] model(input logic [24:0] d, input logic m, input logic h);
        logic [13:0] s;
        if (!m) return {3'b000, d};
        s = h ? d[24:11] : d[13:0];
        return {s, s};
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check(input string tag, input logic [27:0] got, input logic [27:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive one vector at the falling edge, let one rising edge pass, check.
    task automatic apply(input logic [24:0] d, input logic a, input logic b);
        string tag;
        @(negedge clk);
        din = d; cs_a = a; cs_b = b;
        if (!(a && b)) begin
            exp_dout = model(d, fanout_mode, half_sel);
            exp_cs = a;
        end
        @(posedge clk);
        #1;
        if (a && b) tag = "R5";
        else if (!fanout_mode) tag = "R1";
        else if (half_sel) tag = "R4";
        else tag = "R2";
        check(tag, dout, exp_dout);
        check((a && b) ? "R5 cs copy" : "R7", {27'b0, cs_a_q}, {27'b0, exp_cs});
        if (!fanout_mode) check("R3", {25'b0, dout[27:25]}, 28'b0);
    endtask

    task automatic reconfig(input logic m, input logic h);
        @(negedge clk);
        rst_n = 1'b0;
        fanout_mode = m; half_sel = h;
        #1;
        check("R6 reset dout", dout, 28'b0);
        check("R6 reset cs", {27'b0, cs_a_q}, 28'b0);
        exp_dout = '0; exp_cs = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic sweep();
        // walking one and walking zero
        for (int i = 0; i < 25; i++) apply(25'b1 << i, i[0], i[1]);
        for (int i = 0; i < 25; i++) apply(~(25'b1 << i), 1'b0, i[0]);
        // pseudo-random words across all chip-select pairs
        for (int i = 0; i < 64; i++) begin
            seed = next_rand(seed);
            apply(seed[24:0], seed[27], seed[29]);
        end
        // R7: second chip select tied low, first toggles every edge
        for (int i = 0; i < 8; i++) begin
            seed = next_rand(seed);
            apply(seed[24:0], i[0], 1'b0);
        end
    endtask

    initial begin
        #20000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R6: reset state
        repeat (2) @(posedge clk);
        #1;
        check("R6 initial dout", dout, 28'b0);
        check("R6 initial cs", {27'b0, cs_a_q}, 28'b0);

        reconfig(1'b0, 1'b0);
        sweep();
        reconfig(1'b1, 1'b0);
        sweep();
        // R8: low half chosen, only lanes 24..14 move
        apply(25'h0000_2A5, 1'b0, 1'b0);
        @(negedge clk); din = 25'h1FF_C2A5; cs_a = 1'b0; cs_b = 1'b1;
        @(posedge clk); #1;
        check("R8 low half", dout, {14'h02A5, 14'h02A5});
        reconfig(1'b1, 1'b1);
        sweep();
        // R8: high half chosen, only lanes 10..0 move
        apply(25'h155_5800, 1'b1, 1'b0);
        @(negedge clk); din = 25'h155_5FFF; cs_a = 1'b0; cs_b = 1'b0;
        @(posedge clk); #1;
        check("R8 high half", dout, model(25'h155_5800, 1'b1, 1'b1));

        // R6: reset between edges with hold active, then across an edge
        apply(25'h1FF_FFFF, 1'b1, 1'b0);
        @(negedge clk); cs_a = 1'b1; cs_b = 1'b1;
        @(posedge clk); #1;
        rst_n = 1'b0;
        #1;
        check("R6 async dout", dout, 28'b0);
        check("R6 async cs", {27'b0, cs_a_q}, 28'b0);
        @(posedge clk); #1;
        check("R6 over hold", dout, 28'b0);
        exp_dout = '0; exp_cs = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        apply(25'h0AB_CDEF, 1'b0, 1'b1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule